// File: doc/BRIEF.md
# Receive Buffer Ring Descriptor Fetcher

This block keeps the pointers of a circular table of receive-buffer descriptors that sits in system memory. When a fetch is requested, it reads one four-word descriptor through a simple memory read port. It then loads the current buffer address and the remaining buffer space in 16-bit words, moves its read pointer on by one descriptor, wraps the pointer at the end of the table and flags resource exhaustion when the read pointer catches up with the software write pointer.

Once a descriptor is loaded, the receive path reports each stored frame as a byte count that already includes the 4 checksum bytes. The block moves the buffer address on by that count and takes half of it off the remaining word count. When the space left drops below a programmable end-of-buffer threshold, it marks the frame as the last one in that buffer and fetches the next descriptor by itself. Software programs the pointers through a small register port. Software restarts fetching after exhaustion by writing one to the status flag.

Top module: `rxr_fetcher`

## Requirements
- R1: A fetch reads four 16-bit words, index k = 0..3, from address {upper, read pointer} + k*slot, where slot is 2 bytes with `bus_wide` = 0 and 4 bytes with `bus_wide` = 1, taking each word from `mem_rdata` in the cycle `mem_ack` is high. At completion `buf_addr` = {word1, word0} and `buf_words` = {word3, word2}.
- R2: Each completed fetch advances the read pointer by 8 when `bus_wide` = 0 and by 16 when `bus_wide` = 1.
- R3: If the advanced read pointer equals the end pointer, the read pointer becomes the start pointer instead.
- R4: If the read pointer after advance and wrap equals the write pointer, the exhaustion flag (`exhausted`, status register bit 0) is set. The flag changes only at fetch completion or on a status write.
- R5: `fetch_busy` (status bit 2) is high from the cycle after a request until the fetch completes. `mem_req` is high only while busy, and `mem_addr` holds steady until `mem_ack`.
- R6: The start (select 0), end (1), read (2) and write (3) pointer registers ignore bit 0 of a write, so it always reads back as 0.
- R7: Writing 1 to bit 0 of the status register (select 6) while the exhaustion flag is set clears the flag and starts a fetch in the next cycle. With the flag clear, such a write starts nothing.
- R8: A frame report (`frm_valid`, `frm_bytes`) adds `frm_bytes` to `buf_addr` and subtracts `frm_bytes`/2 from `buf_words`.
- R9: If the word count after a frame is below the threshold (select 5), `last_pkt` (status bit 1) is set and a fetch starts in the next cycle. Otherwise `last_pkt` is cleared and no fetch starts.
- R10: Reset sets the threshold to 0x02F8 and clears the pointers, the upper address (select 4), the buffer registers and all status bits.
- R11: A fetch request that arrives while a fetch is running is held, and a second fetch follows once the first one ends.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_wide | input | 1 | 1: descriptor words in 32-bit slots |
| cfg_we | input | 1 | Register write strobe |
| cfg_addr | input | 3 | Register select for write and read |
| cfg_wdata | input | DW | Register write data |
| cfg_rdata | output | DW | Register read data for `cfg_addr` |
| fetch_cmd | input | 1 | Request a descriptor fetch |
| mem_req | output | 1 | Memory read request |
| mem_addr | output | 2*DW | Memory byte address |
| mem_ack | input | 1 | Memory read data valid |
| mem_rdata | input | DW | Memory read data |
| frm_valid | input | 1 | A frame was stored in the buffer |
| frm_bytes | input | DW | Stored byte count including checksum |
| buf_addr | output | 2*DW | Current buffer address |
| buf_words | output | 2*DW | Remaining buffer words |
| last_pkt | output | 1 | Last frame fitted in this buffer |
| exhausted | output | 1 | Descriptor ring exhausted |
| fetch_busy | output | 1 | Fetch in progress |

## Verification
Two functions can land in the same cycle. One is a fetch request, from the command input, a low-space frame or a flag restart. The other is a fetch that is already running. The bench issues a second fetch command one cycle after the first. It then checks that the read pointer has moved by two descriptors once `fetch_busy` falls. The bench also follows a low-space frame report through its automatic refetch, so the frame bookkeeping and the fetch sequencer act on the same buffer registers in turn.

// File: rtl/rxr_pkg.sv
`timescale 1ns/100ps
package rxr_pkg;
  typedef enum logic [2:0] {
    SEL_START  = 3'd0,
    SEL_END    = 3'd1,
    SEL_RDPTR  = 3'd2,
    SEL_WRPTR  = 3'd3,
    SEL_UPPER  = 3'd4,
    SEL_THRESH = 3'd5,
    SEL_STAT   = 3'd6
  } rxr_sel_e;

  typedef enum logic [1:0] {
    FS_IDLE = 2'd0,
    FS_READ = 2'd1,
    FS_DONE = 2'd2
  } rxr_fs_e;
endpackage

// File: rtl/rxr_regs.sv
`timescale 1ns/100ps
module rxr_regs #(
  parameter int              DW         = 16,
  parameter logic [DW-1:0]   THRESH_RST = 16'h02F8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cfg_we,
  input  logic [2:0]    cfg_addr,
  input  logic [DW-1:0] cfg_wdata,
  input  logic          adv,
  input  logic          bus_wide,
  output logic [DW-1:0] start_q,
  output logic [DW-1:0] ring_end_q,
  output logic [DW-1:0] rd_q,
  output logic [DW-1:0] wr_q,
  output logic [DW-1:0] upper_q,
  output logic [DW-1:0] thresh_q,
  output logic          exh_q,
  output logic          restart
);
  import rxr_pkg::*;

  localparam logic [DW-1:0] EVEN_MASK = ~DW'(1);
  localparam logic [DW-1:0] STEP_NAR  = DW'(8);
  localparam logic [DW-1:0] STEP_WID  = DW'(16);

  logic [DW-1:0] start_n, ring_end_n, rd_n, wr_n, upper_n, thresh_n;
  logic          exh_n;
  logic [DW-1:0] adv_ptr;
  logic          upd_en;
  rxr_sel_e      sel;

  assign sel     = rxr_sel_e'(cfg_addr);
  assign restart = cfg_we && (sel == SEL_STAT) && cfg_wdata[0] && exh_q;
  assign upd_en  = cfg_we | adv;

  always_comb begin
    start_n    = start_q;
    ring_end_n = ring_end_q;
    rd_n       = rd_q;
    wr_n       = wr_q;
    upper_n    = upper_q;
    thresh_n   = thresh_q;
    exh_n      = exh_q;
    adv_ptr    = rd_q + (bus_wide ? STEP_WID : STEP_NAR);
    if (adv_ptr == ring_end_q) adv_ptr = start_q;
    if (cfg_we) begin
      case (sel)
        SEL_START:  start_n    = cfg_wdata & EVEN_MASK;
        SEL_END:    ring_end_n = cfg_wdata & EVEN_MASK;
        SEL_RDPTR:  rd_n       = cfg_wdata & EVEN_MASK;
        SEL_WRPTR:  wr_n       = cfg_wdata & EVEN_MASK;
        SEL_UPPER:  upper_n    = cfg_wdata;
        SEL_THRESH: thresh_n   = cfg_wdata;
        default:    ;
      endcase
    end
    if (restart) exh_n = 1'b0;
    if (adv) begin
      rd_n = adv_ptr;
      if (adv_ptr == wr_q) exh_n = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      start_q    <= '0;
      ring_end_q <= '0;
      rd_q       <= '0;
      wr_q       <= '0;
      upper_q    <= '0;
      thresh_q   <= THRESH_RST;
      exh_q      <= 1'b0;
    end else if (upd_en) begin
      start_q    <= start_n;
      ring_end_q <= ring_end_n;
      rd_q       <= rd_n;
      wr_q       <= wr_n;
      upper_q    <= upper_n;
      thresh_q   <= thresh_n;
      exh_q      <= exh_n;
    end
  end
endmodule

// File: rtl/rxr_fetch.sv
`timescale 1ns/100ps
module rxr_fetch #(
  parameter int DW = 16
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            bus_wide,
  input  logic [2*DW-1:0] base_addr,
  input  logic            req_any,
  input  logic            mem_ack,
  input  logic [DW-1:0]   mem_rdata,
  output logic            mem_req,
  output logic [2*DW-1:0] mem_addr,
  output logic            busy,
  output logic            done,
  output logic [2*DW-1:0] ld_addr,
  output logic [2*DW-1:0] ld_cnt
);
  import rxr_pkg::*;

  localparam int AW         = 2 * DW;
  localparam int DESC_WORDS = 4;
  localparam int IW         = $clog2(DESC_WORDS);
  localparam logic [IW-1:0] LAST_IDX = IW'(DESC_WORDS - 1);

  rxr_fs_e       state_q, state_n;
  logic [IW-1:0] idx_q, idx_n;
  logic          pend_q, pend_n;
  logic [DW-1:0] stage_q [DESC_WORDS];
  logic [AW-1:0] offset;
  logic          take;

  assign mem_req = (state_q == FS_READ);
  assign busy    = (state_q != FS_IDLE);
  assign done    = (state_q == FS_DONE);
  assign take    = mem_req && mem_ack;
  assign offset  = bus_wide ? AW'({idx_q, 2'b00}) : AW'({idx_q, 1'b0});
  assign mem_addr = base_addr + offset;

  always_comb begin
    state_n = state_q;
    idx_n   = idx_q;
    pend_n  = pend_q;
    case (state_q)
      FS_IDLE: begin
        if (req_any) begin
          state_n = FS_READ;
          idx_n   = '0;
        end
      end
      FS_READ: begin
        if (req_any) pend_n = 1'b1;
        if (take) begin
          if (idx_q == LAST_IDX) state_n = FS_DONE;
          else                   idx_n   = idx_q + 1'b1;
        end
      end
      FS_DONE: begin
        if (pend_q || req_any) begin
          state_n = FS_READ;
          idx_n   = '0;
          pend_n  = 1'b0;
        end else begin
          state_n = FS_IDLE;
        end
      end
      default: state_n = FS_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= FS_IDLE;
      idx_q   <= '0;
      pend_q  <= 1'b0;
    end else begin
      state_q <= state_n;
      idx_q   <= idx_n;
      pend_q  <= pend_n;
    end
  end

  for (genvar g = 0; g < DESC_WORDS; g++) begin : g_stage
    logic cap_en;
    assign cap_en = take && (idx_q == IW'(g));
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      stage_q[g] <= '0;
      else if (cap_en) stage_q[g] <= mem_rdata;
    end
  end

  assign ld_addr = {stage_q[1], stage_q[0]};
  assign ld_cnt  = {stage_q[3], stage_q[2]};
endmodule

// File: rtl/rxr_space.sv
`timescale 1ns/100ps
module rxr_space #(
  parameter int DW = 16
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            load,
  input  logic [2*DW-1:0] ld_addr,
  input  logic [2*DW-1:0] ld_cnt,
  input  logic            frm_valid,
  input  logic [DW-1:0]   frm_bytes,
  input  logic [DW-1:0]   thresh,
  output logic [2*DW-1:0] buf_addr_q,
  output logic [2*DW-1:0] buf_words_q,
  output logic            last_q,
  output logic            refetch
);
  localparam int AW = 2 * DW;

  logic [AW-1:0] remain, addr_n, words_n;
  logic          below, last_n, upd_en;

  assign remain  = buf_words_q - AW'(frm_bytes >> 1);
  assign below   = remain < AW'(thresh);
  assign refetch = frm_valid && !load && below;
  assign upd_en  = load | frm_valid;

  always_comb begin
    addr_n  = buf_addr_q;
    words_n = buf_words_q;
    last_n  = last_q;
    if (load) begin
      addr_n  = ld_addr;
      words_n = ld_cnt;
    end else if (frm_valid) begin
      addr_n  = buf_addr_q + AW'(frm_bytes);
      words_n = remain;
      last_n  = below;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      buf_addr_q  <= '0;
      buf_words_q <= '0;
      last_q      <= 1'b0;
    end else if (upd_en) begin
      buf_addr_q  <= addr_n;
      buf_words_q <= words_n;
      last_q      <= last_n;
    end
  end
endmodule

// File: rtl/rxr_fetcher.sv
`timescale 1ns/100ps
module rxr_fetcher #(
  parameter int              DW         = 16,
  parameter logic [DW-1:0]   THRESH_RST = 16'h02F8
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            bus_wide,
  input  logic            cfg_we,
  input  logic [2:0]      cfg_addr,
  input  logic [DW-1:0]   cfg_wdata,
  output logic [DW-1:0]   cfg_rdata,
  input  logic            fetch_cmd,
  output logic            mem_req,
  output logic [2*DW-1:0] mem_addr,
  input  logic            mem_ack,
  input  logic [DW-1:0]   mem_rdata,
  input  logic            frm_valid,
  input  logic [DW-1:0]   frm_bytes,
  output logic [2*DW-1:0] buf_addr,
  output logic [2*DW-1:0] buf_words,
  output logic            last_pkt,
  output logic            exhausted,
  output logic            fetch_busy
);
  import rxr_pkg::*;

  localparam int AW = 2 * DW;

  logic [DW-1:0] start_q, ring_end_q, rd_q, wr_q, upper_q, thresh_q;
  logic          restart, refetch, req_any, done;
  logic [AW-1:0] ld_addr, ld_cnt;

  assign req_any = fetch_cmd | refetch | restart;

  rxr_regs #(.DW(DW), .THRESH_RST(THRESH_RST)) u_regs (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
    .cfg_wdata(cfg_wdata), .adv(done), .bus_wide(bus_wide),
    .start_q(start_q), .ring_end_q(ring_end_q), .rd_q(rd_q), .wr_q(wr_q),
    .upper_q(upper_q), .thresh_q(thresh_q), .exh_q(exhausted),
    .restart(restart)
  );

  rxr_fetch #(.DW(DW)) u_fetch (
    .clk(clk), .rst_n(rst_n), .bus_wide(bus_wide),
    .base_addr({upper_q, rd_q}), .req_any(req_any),
    .mem_ack(mem_ack), .mem_rdata(mem_rdata), .mem_req(mem_req),
    .mem_addr(mem_addr), .busy(fetch_busy), .done(done),
    .ld_addr(ld_addr), .ld_cnt(ld_cnt)
  );

  rxr_space #(.DW(DW)) u_space (
    .clk(clk), .rst_n(rst_n), .load(done), .ld_addr(ld_addr),
    .ld_cnt(ld_cnt), .frm_valid(frm_valid), .frm_bytes(frm_bytes),
    .thresh(thresh_q), .buf_addr_q(buf_addr), .buf_words_q(buf_words),
    .last_q(last_pkt), .refetch(refetch)
  );

  always_comb begin
    cfg_rdata = '0;
    case (rxr_sel_e'(cfg_addr))
      SEL_START:  cfg_rdata = start_q;
      SEL_END:    cfg_rdata = ring_end_q;
      SEL_RDPTR:  cfg_rdata = rd_q;
      SEL_WRPTR:  cfg_rdata = wr_q;
      SEL_UPPER:  cfg_rdata = upper_q;
      SEL_THRESH: cfg_rdata = thresh_q;
      SEL_STAT:   cfg_rdata = DW'({fetch_busy, last_pkt, exhausted});
      default:    cfg_rdata = '0;
    endcase
  end
endmodule

// File: rtl/rxr_fetcher_chk.sv
`timescale 1ns/100ps
module rxr_fetcher_chk #(
  parameter int DW = 16
) (
  input logic            clk,
  input logic            rst_n,
  input logic            cfg_we,
  input logic [2:0]      cfg_addr,
  input logic [DW-1:0]   cfg_wdata,
  input logic            mem_req,
  input logic            mem_ack,
  input logic [2*DW-1:0] mem_addr,
  input logic            frm_valid,
  input logic [DW-1:0]   frm_bytes,
  input logic [2*DW-1:0] buf_words,
  input logic            last_pkt,
  input logic            exhausted,
  input logic            fetch_busy,
  input logic [DW-1:0]   thresh_q
);
  localparam int AW = 2 * DW;

  logic stat_w1;
  logic low_frame;
  assign stat_w1   = cfg_we && (cfg_addr == 3'd6) && cfg_wdata[0];
  assign low_frame = frm_valid && !fetch_busy &&
                     ((buf_words - AW'(frm_bytes >> 1)) < AW'(thresh_q));

  AST_REQ_IN_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req |-> fetch_busy);                                        // R5
  AST_ADDR_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && !mem_ack) |=> (mem_req && $stable(mem_addr)));      // R5
  AST_RESTART: assert property (@(posedge clk) disable iff (!rst_n)
    (stat_w1 && exhausted && !fetch_busy) |=> (!exhausted && fetch_busy)); // R7
  AST_LOW_REFETCH: assert property (@(posedge clk) disable iff (!rst_n)
    low_frame |=> (last_pkt && fetch_busy));                        // R9
  AST_EXH_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    (!fetch_busy && !cfg_we) |=> $stable(exhausted));               // R4
endmodule

bind rxr_fetcher rxr_fetcher_chk #(.DW(DW)) u_chk (
  .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
  .cfg_wdata(cfg_wdata), .mem_req(mem_req), .mem_ack(mem_ack),
  .mem_addr(mem_addr), .frm_valid(frm_valid), .frm_bytes(frm_bytes),
  .buf_words(buf_words), .last_pkt(last_pkt), .exhausted(exhausted),
  .fetch_busy(fetch_busy), .thresh_q(thresh_q)
);

// File: tb/sim_rxr_fetcher.sv
`timescale 1ns/100ps
module sim_rxr_fetcher;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        bus_wide;
  logic        cfg_we;
  logic [2:0]  cfg_addr;
  logic [15:0] cfg_wdata;
  logic [15:0] cfg_rdata;
  logic        fetch_cmd;
  logic        mem_req;
  logic [31:0] mem_addr;
  logic        mem_ack;
  logic [15:0] mem_rdata;
  logic        frm_valid;
  logic [15:0] frm_bytes;
  logic [31:0] buf_addr;
  logic [31:0] buf_words;
  logic        last_pkt;
  logic        exhausted;
  logic        fetch_busy;

  int checks = 0;
  int fails  = 0;
  logic [15:0] mem_img [0:127];

  always #2.5 clk = ~clk;

  rxr_fetcher u0 (
    .clk(clk), .rst_n(rst_n), .bus_wide(bus_wide), .cfg_we(cfg_we),
    .cfg_addr(cfg_addr), .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata),
    .fetch_cmd(fetch_cmd), .mem_req(mem_req), .mem_addr(mem_addr),
    .mem_ack(mem_ack), .mem_rdata(mem_rdata), .frm_valid(frm_valid),
    .frm_bytes(frm_bytes), .buf_addr(buf_addr), .buf_words(buf_words),
    .last_pkt(last_pkt), .exhausted(exhausted), .fetch_busy(fetch_busy)
  );

  always @(negedge clk) begin
    mem_ack   <= mem_req;
    mem_rdata <= mem_img[mem_addr[7:1]];
  end

  typedef struct packed {
    logic        wide;
    logic [15:0] st;
    logic [15:0] en;
    logic [15:0] rd;
    logic [15:0] wr;
    logic [15:0] exp_rd;
    logic        exp_exh;
  } vec_t;

  localparam int NV = 5;
  localparam vec_t VECS [NV] = '{
    '{1'b0, 16'h0100, 16'h0140, 16'h0100, 16'h0120, 16'h0108, 1'b0},
    '{1'b0, 16'h0100, 16'h0140, 16'h0138, 16'h0120, 16'h0100, 1'b0},
    '{1'b0, 16'h0101, 16'h0141, 16'h0119, 16'h0121, 16'h0120, 1'b1},
    '{1'b1, 16'h0100, 16'h0140, 16'h0100, 16'h0120, 16'h0110, 1'b0},
    '{1'b1, 16'h0100, 16'h0140, 16'h0130, 16'h0100, 16'h0100, 1'b1}
  };

  task automatic chk(input string req, input logic [31:0] got, input logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, got, exp);
    end
  endtask

  function automatic logic [15:0] exp_word(input logic [15:0] rd, input int k, input logic wide);
    logic [7:0] lo;
    lo = rd[7:0] + 8'(wide ? 4 * k : 2 * k);
    return mem_img[lo[7:1]];
  endfunction

  task automatic do_reset();
    rst_n = 1'b0; bus_wide = 1'b0; cfg_we = 1'b0; cfg_addr = '0;
    cfg_wdata = '0; fetch_cmd = 1'b0; frm_valid = 1'b0; frm_bytes = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
  endtask

  task automatic wr_reg(input logic [2:0] a, input logic [15:0] d);
    @(negedge clk);
    cfg_we = 1'b1; cfg_addr = a; cfg_wdata = d;
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  task automatic rd_reg(input logic [2:0] a, output logic [15:0] d);
    cfg_addr = a;
    #0.5;
    d = cfg_rdata;
  endtask

  task automatic pulse_fetch();
    @(negedge clk);
    fetch_cmd = 1'b1;
    @(negedge clk);
    fetch_cmd = 1'b0;
  endtask

  task automatic wait_idle();
    int n = 0;
    while (fetch_busy && n < 60) begin
      @(negedge clk);
      n++;
    end
    if (fetch_busy) chk("R5 fetch completes", 32'(fetch_busy), 32'd0);
  endtask

  task automatic frame(input logic [15:0] b);
    @(negedge clk);
    frm_valid = 1'b1; frm_bytes = b;
    @(negedge clk);
    frm_valid = 1'b0;
  endtask

  initial begin
    #900000;
    fails++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    logic [15:0] v;
    logic [15:0] rdm;
    for (int i = 0; i < 128; i++) mem_img[i] = 16'hC000 ^ 16'(i * 291);
    mem_img[7'h40] = 16'h2000; mem_img[7'h41] = 16'h0012;
    mem_img[7'h42] = 16'h0400; mem_img[7'h43] = 16'h0000;
    mem_img[7'h44] = 16'h3000; mem_img[7'h45] = 16'h0012;
    mem_img[7'h46] = 16'h0800; mem_img[7'h47] = 16'h0000;

    do_reset();
    // R10 reset state
    rd_reg(3'd5, v); chk("R10 threshold", 32'(v), 32'h02F8);
    rd_reg(3'd2, v); chk("R10 read ptr", 32'(v), 32'h0);
    rd_reg(3'd6, v); chk("R10 status", 32'(v), 32'h0);
    chk("R10 buf_words", buf_words, 32'h0);
    chk("R10 mem_req", 32'(mem_req), 32'h0);

    // table of ring configurations: R1 R2 R3 R4 R6
    for (int n = 0; n < NV; n++) begin
      do_reset();
      bus_wide = VECS[n].wide;
      wr_reg(3'd4, 16'h0012);
      wr_reg(3'd0, VECS[n].st);
      wr_reg(3'd1, VECS[n].en);
      wr_reg(3'd2, VECS[n].rd);
      wr_reg(3'd3, VECS[n].wr);
      rdm = VECS[n].rd & 16'hFFFE;
      pulse_fetch();
      chk("R5 busy after request", 32'(fetch_busy), 32'd1);
      wait_idle();
      chk("R1 buffer address", buf_addr,
          {exp_word(rdm, 1, VECS[n].wide), exp_word(rdm, 0, VECS[n].wide)});
      chk("R1 word count", buf_words,
          {exp_word(rdm, 3, VECS[n].wide), exp_word(rdm, 2, VECS[n].wide)});
      rd_reg(3'd2, v); chk("R2 R3 read ptr", 32'(v), 32'(VECS[n].exp_rd));
      chk("R4 exhaustion", 32'(exhausted), 32'(VECS[n].exp_exh));
    end

    // R6 bit 0 ignored on all four pointers
    do_reset();
    for (int a = 0; a < 4; a++) begin
      wr_reg(3'(a), 16'hFFFF);
      rd_reg(3'(a), v);
      chk("R6 pointer bit0", 32'(v), 32'hFFFE);
    end

    // R7 restart through status write
    do_reset();
    wr_reg(3'd4, 16'h0012); wr_reg(3'd0, 16'h0100); wr_reg(3'd1, 16'h0140);
    wr_reg(3'd2, 16'h0118); wr_reg(3'd3, 16'h0120);
    pulse_fetch(); wait_idle();
    chk("R4 exhausted before restart", 32'(exhausted), 32'd1);
    wr_reg(3'd6, 16'h0001);
    chk("R7 flag cleared", 32'(exhausted), 32'd0);
    chk("R7 fetch started", 32'(fetch_busy), 32'd1);
    wait_idle();
    rd_reg(3'd2, v); chk("R7 restart fetch advanced", 32'(v), 32'h0128);
    wr_reg(3'd6, 16'h0001);
    chk("R7 no fetch when flag clear", 32'(fetch_busy), 32'd0);
    rd_reg(3'd2, v); chk("R7 pointer unchanged", 32'(v), 32'h0128);

    // R11 request held during running fetch
    do_reset();
    wr_reg(3'd4, 16'h0012); wr_reg(3'd0, 16'h0100); wr_reg(3'd1, 16'h0140);
    wr_reg(3'd2, 16'h0100); wr_reg(3'd3, 16'h0130);
    pulse_fetch();
    fetch_cmd = 1'b1;
    @(negedge clk);
    fetch_cmd = 1'b0;
    wait_idle();
    rd_reg(3'd2, v); chk("R11 two fetches", 32'(v), 32'h0110);

    // R8 R9 frame bookkeeping and low-space refetch
    do_reset();
    wr_reg(3'd4, 16'h0012); wr_reg(3'd0, 16'h0100); wr_reg(3'd1, 16'h01C0);
    wr_reg(3'd2, 16'h0180); wr_reg(3'd3, 16'h01A0); wr_reg(3'd5, 16'h0300);
    pulse_fetch(); wait_idle();
    chk("R1 loaded count", buf_words, 32'h0000_0400);
    frame(16'h0100);
    chk("R8 words after frame", buf_words, 32'h0000_0380);
    chk("R8 address after frame", buf_addr, 32'h0012_2100);
    chk("R9 last clear", 32'(last_pkt), 32'd0);
    chk("R9 no refetch", 32'(fetch_busy), 32'd0);
    frame(16'h0120);
    chk("R8 words below threshold", buf_words, 32'h0000_02F0);
    chk("R9 last set", 32'(last_pkt), 32'd1);
    chk("R9 refetch started", 32'(fetch_busy), 32'd1);
    wait_idle();
    chk("R9 new buffer address", buf_addr, 32'h0012_3000);
    chk("R9 new word count", buf_words, 32'h0000_0800);
    rd_reg(3'd2, v); chk("R2 after refetch", 32'(v), 32'h0190);

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule